// File: doc/BRIEF.md
# Timer Control and External Interrupt Request Register

This block is an 8-bit control register that a CPU reaches in its special-function space. It holds the run enables for two timer counters and the overflow flags those timers raise. It also holds the request logic for two active-low external interrupt pins, each with a selectable trigger type. The CPU can write the register as a whole byte or one bit at a time, and can read it as a byte. The timers return one-cycle overflow strobes, and the interrupt controller returns one-cycle vector-acknowledge strobes for each source.

Each external pin passes through a two-flop synchronizer. In edge mode, a 1-to-0 change of the synchronized pin latches a request, and that request stays set until the source is vectored or software clears it. In level mode, the request flag simply mirrors the inverted synchronized pin. Vector acknowledges and CPU writes do not change it in that mode. The four request flags are driven out as an interrupt request vector.

Top module: `tmr_ctl_reg`

## Requirements
- R1: After reset, the register reads 0x00, `run_en` is 0 and `irq` is 0.
- R2: A byte write with `sfr_addr` equal to BASE_ADDR (default 0x88) loads all eight bits from `sfr_wdata`. `sfr_rdata` returns the register when `sfr_addr` equals BASE_ADDR and 0x00 at any other address. Byte writes to other addresses change nothing.
- R3: A bit write at `bit_addr` = BASE_ADDR + i (i = 0..7) loads bit i from `bit_wval`. Bit addresses outside that group of eight change nothing. When a byte write and a bit write occur in the same cycle, the byte write is used.
- R4: The bit layout, from bit 7 down to bit 0, is: timer 1 flag, timer 1 run, timer 0 flag, timer 0 run, external 1 request, external 1 trigger type, external 0 request, external 0 trigger type.
- R5: `run_en[1]` is bit 6 and `run_en[0]` is bit 4. Only CPU writes change these bits.
- R6: An overflow strobe `tmr_ovf[n]` sets the flag of timer n on the next clock edge.
- R7: A vector acknowledge clears the flag of timer n on the next clock edge. The acknowledge is `ack[1]` for timer 0 and `ack[3]` for timer 1.
- R8: When a hardware set event (an overflow, or a detected falling edge in edge mode) coincides with a CPU write or an acknowledge to the same flag, the flag is set.
- R9: When trigger-type bit n is 1 (edge mode), a 1-to-0 transition of `ext_pin_n[n]` sets request n. The flag becomes visible three clock edges after the pin changes: two synchronizer stages, then the flag register.
- R10: In edge mode, request n is cleared by its acknowledge (`ack[0]` for external 0, `ack[2]` for external 1) and can also be written by the CPU. A pin that stays low does not set the request again.
- R11: When trigger-type bit n is 0 (level mode), request n equals the inverse of the synchronized pin, with the same three-edge delay. Acknowledges and CPU writes have no effect on it.
- R12: `irq` is ordered {timer 1 flag, external 1 request, timer 0 flag, external 0 request} from bit 3 down to bit 0.
- R13: The trigger-type bits and the external pins have no effect on `run_en` or on the timer flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sfr_addr | input | ADDR_W | Byte access address |
| sfr_wr | input | 1 | Byte write strobe |
| sfr_wdata | input | 8 | Byte write data |
| sfr_rdata | output | 8 | Byte read data (0 when not addressed) |
| bit_addr | input | ADDR_W | Bit access address |
| bit_wr | input | 1 | Bit write strobe |
| bit_wval | input | 1 | Bit write value |
| tmr_ovf | input | 2 | Overflow strobes from timers 1 and 0 |
| ext_pin_n | input | 2 | Asynchronous active-low external interrupt pins |
| ack | input | 4 | Vector-acknowledge strobes, same order as irq |
| run_en | output | 2 | Run enables to timers 1 and 0 |
| irq | output | 4 | Request flags to the interrupt controller |

## Verification
The bench drives an overflow or a falling edge in the same cycle as a clearing write or an acknowledge. A design that let the clear win would drop an interrupt. It switches trigger type while a pin is held low and sends acknowledges and writes to a level-mode flag. A design that latched a level request, or let an acknowledge clear it, would report a request the pin no longer makes. It holds a pin low through an acknowledge in edge mode, which catches a detector that fires on level rather than on transition. It also aims writes at neighbouring byte and bit addresses, which exposes loose address decoding.

// File: rtl/tcer_pkg.sv
package tcer_pkg;
  localparam int unsigned REG_W = 8;
  // bit positions inside the control byte
  localparam int unsigned B_IT0 = 0;
  localparam int unsigned B_IE0 = 1;
  localparam int unsigned B_IT1 = 2;
  localparam int unsigned B_IE1 = 3;
  localparam int unsigned B_TR0 = 4;
  localparam int unsigned B_TF0 = 5;
  localparam int unsigned B_TR1 = 6;
  localparam int unsigned B_TF1 = 7;

  function automatic logic [REG_W-1:0] bit_onehot(input logic [2:0] idx);
    return REG_W'(1) << idx;
  endfunction

  // set wins over write, write wins over acknowledge clear
  function automatic logic flag_next(input logic cur, input logic hw_set,
                                     input logic wr_en, input logic wr_val,
                                     input logic clr);
    if (hw_set)     return 1'b1;
    else if (wr_en) return wr_val;
    else if (clr)   return 1'b0;
    else            return cur;
  endfunction
endpackage

// File: rtl/tcer_sync.sv
module tcer_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_lane
    logic [STAGES-1:0] sr;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '1;   // idle-high pins: no false edge out of reset
      else        sr <= {sr[STAGES-2:0], async_in[g]};
    end
    assign sync_out[g] = sr[STAGES-1];
  end
endmodule

// File: rtl/tcer_tmr_flag.sv
module tcer_tmr_flag
  import tcer_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ovf,
  input  logic ack,
  input  logic wr_en,
  input  logic wr_val,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_next(flag, ovf, wr_en, wr_val, ack);
  end

  // R6 / R8: an overflow is never lost
  p_ovf_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> flag);
  // R7: a lone acknowledge clears
  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !ovf && !wr_en) |=> !flag);
endmodule

// File: rtl/tcer_ext_req.sv
module tcer_ext_req
  import tcer_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  input  logic edge_mode,
  input  logic ack,
  input  logic wr_en,
  input  logic wr_val,
  output logic flag,
  output logic fall_evt
);
  logic pin_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_prev <= 1'b1;
    else        pin_prev <= pin_s;
  end

  assign fall_evt = pin_prev & ~pin_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag <= 1'b0;
    else if (edge_mode) flag <= flag_next(flag, fall_evt, wr_en, wr_val, ack);
    else                flag <= ~pin_s;
  end

  // R9 / R8: a detected edge always latches
  p_edge_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && fall_evt) |=> flag);
  // R11: level mode mirrors the pin regardless of ack or write
  p_level_track_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_mode |=> (flag == !$past(pin_s)));
endmodule

// File: rtl/tmr_ctl_reg.sv
module tmr_ctl_reg
  import tcer_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned BASE_ADDR   = 'h88,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic              sfr_wr,
  input  logic [REG_W-1:0]  sfr_wdata,
  output logic [REG_W-1:0]  sfr_rdata,
  input  logic [ADDR_W-1:0] bit_addr,
  input  logic              bit_wr,
  input  logic              bit_wval,
  input  logic [1:0]        tmr_ovf,
  input  logic [1:0]        ext_pin_n,
  input  logic [3:0]        ack,
  output logic [1:0]        run_en,
  output logic [3:0]        irq
);
  localparam logic [ADDR_W-1:0] BASE_A  = BASE_ADDR[ADDR_W-1:0];
  localparam logic [ADDR_W-4:0] BIT_GRP = BASE_A[ADDR_W-1:3];
  localparam int unsigned N_SRC = 2;

  logic             byte_hit, bit_hit;
  logic [REG_W-1:0] wr_en, wr_val, ctl;
  logic [N_SRC-1:0] pin_s, fall_evt;

  assign byte_hit = sfr_wr && (sfr_addr == BASE_A);
  assign bit_hit  = bit_wr && (bit_addr[ADDR_W-1:3] == BIT_GRP);

  always_comb begin
    wr_en  = '0;
    wr_val = '0;
    if (byte_hit) begin
      wr_en  = '1;
      wr_val = sfr_wdata;
    end else if (bit_hit) begin
      wr_en  = bit_onehot(bit_addr[2:0]);
      wr_val = {REG_W{bit_wval}};
    end
  end

  tcer_sync #(.WIDTH(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ext_pin_n), .sync_out(pin_s)
  );

  // software-only bits: run enables and trigger types (even positions)
  for (genvar g = 0; g < 4; g++) begin : g_soft
    localparam int unsigned POS = 2 * g;
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q <= 1'b0;
      else if (wr_en[POS]) q <= wr_val[POS];
    end
    assign ctl[POS] = q;
  end

  for (genvar n = 0; n < N_SRC; n++) begin : g_src
    localparam int unsigned TF = B_TF0 + 2 * n;
    localparam int unsigned IE = B_IE0 + 2 * n;
    localparam int unsigned IT = B_IT0 + 2 * n;

    tcer_tmr_flag u_tf (
      .clk(clk), .rst_n(rst_n), .ovf(tmr_ovf[n]), .ack(ack[2*n+1]),
      .wr_en(wr_en[TF]), .wr_val(wr_val[TF]), .flag(ctl[TF])
    );

    tcer_ext_req u_ie (
      .clk(clk), .rst_n(rst_n), .pin_s(pin_s[n]), .edge_mode(ctl[IT]),
      .ack(ack[2*n]), .wr_en(wr_en[IE]), .wr_val(wr_val[IE]),
      .flag(ctl[IE]), .fall_evt(fall_evt[n])
    );

    assign run_en[n]  = ctl[B_TR0 + 2 * n];
    assign irq[2*n]   = ctl[IE];
    assign irq[2*n+1] = ctl[TF];
  end

  assign sfr_rdata = (sfr_addr == BASE_A) ? ctl : '0;

  // R5: run enables move only on a CPU write
  p_run_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en[B_TR0] && !wr_en[B_TR1]) |=> $stable(run_en));
  // R2: an unaddressed read returns zero
  p_read_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_addr != BASE_A) |-> (sfr_rdata == '0));
endmodule

// File: tb/test_tmr_ctl_reg.sv
module test_tmr_ctl_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] sfr_addr = 8'h88;
  logic       sfr_wr = 1'b0;
  logic [7:0] sfr_wdata = 8'h00;
  logic [7:0] sfr_rdata;
  logic [7:0] bit_addr = 8'h00;
  logic       bit_wr = 1'b0;
  logic       bit_wval = 1'b0;
  logic [1:0] tmr_ovf = 2'b00;
  logic [1:0] ext_pin_n = 2'b11;
  logic [3:0] ack = 4'h0;
  logic [1:0] run_en;
  logic [3:0] irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] mdl = 8'h00;
  bit h0[$];
  bit h1[$];

  always #5 clk = ~clk;

  tmr_ctl_reg i_tmr_ctl_reg (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .bit_addr(bit_addr),
    .bit_wr(bit_wr), .bit_wval(bit_wval), .tmr_ovf(tmr_ovf),
    .ext_pin_n(ext_pin_n), .ack(ack), .run_en(run_en), .irq(irq)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // reference: behaviour of the register after one clock edge
  task automatic model_step();
    logic [7:0] en, val, nxt;
    bit s, p;
    en = 8'h00; val = 8'h00;
    if (sfr_wr && sfr_addr == 8'h88) begin en = 8'hFF; val = sfr_wdata; end
    else if (bit_wr && bit_addr >= 8'h88 && bit_addr <= 8'h8F) begin
      en[bit_addr - 8'h88] = 1'b1; val = {8{bit_wval}};
    end
    h0.push_back(ext_pin_n[0]);
    h1.push_back(ext_pin_n[1]);
    nxt = mdl;
    foreach (nxt[i]) if ((i % 2) == 0 && en[i]) nxt[i] = val[i];
    for (int n = 0; n < 2; n++) begin
      int tf = 5 + 2*n;
      int ie = 1 + 2*n;
      int it = 2*n;
      if (tmr_ovf[n]) nxt[tf] = 1'b1;
      else if (en[tf]) nxt[tf] = val[tf];
      else if (ack[2*n+1]) nxt[tf] = 1'b0;
      s = (n == 0) ? h0[h0.size()-3] : h1[h1.size()-3];
      p = (n == 0) ? h0[h0.size()-4] : h1[h1.size()-4];
      if (mdl[it]) begin
        if (p && !s) nxt[ie] = 1'b1;
        else if (en[ie]) nxt[ie] = val[ie];
        else if (ack[2*n]) nxt[ie] = 1'b0;
      end else nxt[ie] = !s;
    end
    mdl = nxt;
    if (h0.size() > 8) begin void'(h0.pop_front()); void'(h1.pop_front()); end
  endtask

  task automatic compare(input string tag);
    chk(tag, "rdata", sfr_rdata, (sfr_addr == 8'h88) ? mdl : 8'h00);
    chk(tag, "run_en", run_en, {mdl[6], mdl[4]});
    chk(tag, "irq", irq, {mdl[7], mdl[3], mdl[5], mdl[1]});
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag);
    sfr_wr = 0; bit_wr = 0; tmr_ovf = 0; ack = 0; sfr_addr = 8'h88;
  endtask

  task automatic cycs(input string tag, input int k);
    for (int i = 0; i < k; i++) cyc(tag);
  endtask

  task automatic bwrite(input logic [7:0] d);
    sfr_wr = 1; sfr_wdata = d;
  endtask

  task automatic bitw(input logic [7:0] a, input logic v);
    bit_wr = 1; bit_addr = a; bit_wval = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin h0.push_back(1); h1.push_back(1); end
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1;
    cycs("R1", 3);

    // R2 / R4: byte write, edge mode on both, both timers running
    bwrite(8'h55); cyc("R2");
    cycs("R4", 2);
    sfr_addr = 8'h89; sfr_wr = 1; sfr_wdata = 8'hFF; cyc("R2");
    cyc("R2");

    // R3: bit writes, out-of-group ignored, byte wins over bit
    bitw(8'h8E, 0); cyc("R3");
    bitw(8'h90, 1); cyc("R3");
    bitw(8'h87, 1); cyc("R3");
    bitw(8'h8E, 1); bwrite(8'h15); cyc("R3");
    bitw(8'h8E, 1); cyc("R5");

    // R6 / R7 / R8 timer flags
    tmr_ovf = 2'b01; cyc("R6");
    ack = 4'b0010; cyc("R7");
    tmr_ovf = 2'b10; cyc("R6");
    tmr_ovf = 2'b10; ack = 4'b1000; cyc("R8");
    tmr_ovf = 2'b01; bwrite(8'h55); cyc("R8");
    ack = 4'b1000; cyc("R7");
    ack = 4'b0010; cyc("R7");
    tmr_ovf = 2'b10; bitw(8'h8F, 0); cyc("R8");
    bitw(8'h8F, 0); cyc("R7");

    // R9 / R10 edge mode on external 0
    ext_pin_n[0] = 0; cycs("R9", 4);
    ext_pin_n[0] = 1; cyc("R9");
    ack = 4'b0001; cyc("R10");
    ext_pin_n[0] = 0; cycs("R10", 5);
    ack = 4'b0001; cycs("R10", 4);
    bitw(8'h89, 1); cyc("R10");
    bitw(8'h89, 0); cyc("R10");
    ext_pin_n[0] = 1; cycs("R9", 3);
    ext_pin_n[0] = 0; cyc("R8");
    cyc("R8");
    ack = 4'b0001; bitw(8'h89, 0); cyc("R8");
    cycs("R12", 2);
    ack = 4'b0001; cyc("R10");
    ext_pin_n[0] = 1; cycs("R10", 3);

    // R11 level mode on external 1
    bitw(8'h8A, 0); cyc("R11");
    ext_pin_n[1] = 0; cycs("R11", 4);
    ack = 4'b0100; cyc("R11");
    bitw(8'h8B, 0); cyc("R11");
    bwrite(8'h50); cyc("R11");
    ext_pin_n[1] = 1; cycs("R11", 4);
    ext_pin_n[1] = 0; cyc("R11");
    bitw(8'h8A, 1); cycs("R11", 4);
    ext_pin_n[1] = 1; cycs("R11", 3);

    // R13: pins and trigger types leave timer bits alone
    bwrite(8'hF0); cyc("R13");
    for (int i = 0; i < 20; i++) begin
      ext_pin_n = 2'(i);
      if (i % 3 == 0) bitw(8'h88 + 8'(2 * (i % 2)), 1'(i / 3));
      cyc("R13");
    end

    // mixed stimulus against the model
    for (int i = 0; i < 400; i++) begin
      tmr_ovf = 2'($urandom_range(0, 3)) & 2'($urandom_range(0, 3));
      ack = 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15));
      if ($urandom_range(0, 7) == 0) ext_pin_n = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 9) == 0) begin
        sfr_addr = 8'($urandom_range(8'h86, 8'h8A)); sfr_wr = 1;
        sfr_wdata = 8'($urandom_range(0, 255));
      end
      if ($urandom_range(0, 7) == 0) bitw(8'($urandom_range(8'h86, 8'h91)), 1'($urandom_range(0, 1)));
      cyc("R8");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule